// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Execute Stall and RAW Interlock

This block runs a short program of simple instruction tokens through four concurrent stages: fetch, decode with register read, execute, and store of the result. Holding registers sit between the stages. Each token names an operation, a count of extra execute cycles, a destination register, a source register and an 8-bit immediate. Tokens are read combinationally from an instruction array outside the block. The array is addressed by the block's fetch pointer. Results land in an eight-entry register file inside the block.

Execute may take more than one cycle. While it works, the decode and fetch holding registers freeze, and empty slots flow into the store stage. When a token needs a register that the token ahead of it has not yet written, decode holds it back and feeds one empty slot into execute. There is no forwarding between stages. A value being written by the store stage is passed straight through to a decode read in the same cycle. The stall line and a retire strobe let an environment compare both timing and results against a sequential model.

Top module: `pipe4_core`

## Requirements
- R1: While reset is low and in the first cycle after its release, `fetch_addr_o` is 0 and `stall_o` and `retire_valid_o` are low. Reset also clears every register file entry to 0.
- R2: An instruction word is {op[17:16], xlat[15:14], dst[13:11], src[10:8], imm[7:0]}. Op 1 writes src+imm, op 2 writes src*imm, and op 3 writes imm. Results are truncated to the data width, with imm zero-extended. Op 0 is the end marker.
- R3: With xlat=0 and no dependences, the first token retires in the 4th cycle after reset release, and each following token retires one cycle later. Four tokens finish in cycle 7.
- R4: A token with xlat=L stays in execute for L+1 cycles. `stall_o` is high for the first L of those cycles. In each cycle where a hold applies, the fetch pointer and the decode holding register keep their contents.
- R5: Each stalled execute cycle sends an empty slot into store, so `retire_valid_o` is low in the cycle after each stalled cycle.
- R6: A token that reads the destination of the token directly ahead of it (ops 1 and 2) enters execute one cycle after its producer leaves execute, and it uses the produced value. For example, 10, then +5, then ×2 yields 30.
- R7: A token whose source was written by the token two ahead incurs no extra delay and reads the new value, which is bypassed from the store stage.
- R8: On the end marker, fetch stops. `fetch_addr_o` stays on the marker, and no further tokens retire.
- R9: Tokens retire in program order. `retire_valid_o` is high for exactly one cycle per token, carrying its destination on `retire_tag_o` and its result on `retire_value_o`, and the register file is updated with that value.
- R10: Op 3 ignores its src field, so a matching destination ahead of it causes no interlock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_addr_o | output | PC_W | Fetch pointer into the instruction array |
| fetch_word_i | input | 18 | Instruction word at `fetch_addr_o`, same cycle |
| stall_o | output | 1 | Execute is busy with a multi-cycle token |
| retire_valid_o | output | 1 | A token is in the store stage this cycle |
| retire_tag_o | output | 3 | Destination register of the retiring token |
| retire_value_o | output | DATA_W | Result of the retiring token |

## Verification
An execute counter that does not return to zero shows up as a stretched `stall_o` window, visible one cycle after the token enters execute. A missed interlock or a stale register file entry shows up as a wrong `retire_value_o`. That error appears on the consumer's retire cycle, typically two to four cycles after its producer retired. A holding register that fails to freeze during a stall either drops a token or duplicates one, which breaks the retire sequence at the next retire slot. A fetch pointer that is not frozen leaves a wrong final `fetch_addr_o` at the end marker.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

  localparam int OP_W    = 2;
  localparam int LAT_W   = 2;
  localparam int TAG_W   = 3;
  localparam int IMM_W   = 8;
  localparam int REG_CNT = 1 << TAG_W;
  localparam int INSTR_W = OP_W + LAT_W + 2 * TAG_W + IMM_W;

  typedef enum logic [OP_W-1:0] {
    OP_HALT = 2'd0,
    OP_ADDI = 2'd1,
    OP_MULI = 2'd2,
    OP_LDI  = 2'd3
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [LAT_W-1:0] xlat;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] src;
    logic [IMM_W-1:0] imm;
  } instr_t;

  function automatic logic reads_src(op_e op);
    return (op == OP_ADDI) || (op == OP_MULI);
  endfunction

endpackage

// File: rtl/p4_fetch.sv
module p4_fetch
  import pipe4_pkg::*;
#(
  parameter int PC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [PC_W-1:0]    addr_o,
  output logic               fd_valid_o,
  output instr_t             fd_instr_o
);

  instr_t            fetched;
  logic              at_end;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              v_q, v_d;
  instr_t            ins_q;
  logic              ins_en;

  assign fetched = instr_t'(word_i);
  assign at_end  = (fetched.op == OP_HALT);

  always_comb begin
    pc_d   = pc_q;
    v_d    = v_q;
    ins_en = 1'b0;
    if (!hold_i) begin
      v_d = !at_end;
      if (!at_end) begin
        pc_d   = pc_q + 1'b1;
        ins_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      v_q  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      v_q  <= v_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins_en) ins_q <= fetched;
  end

  assign addr_o     = pc_q;
  assign fd_valid_o = v_q;
  assign fd_instr_o = ins_q;

  assert_hold_freezes_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (addr_o == $past(addr_o)) && (fd_valid_o == $past(fd_valid_o)));

  assert_end_marker_parks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && at_end) |=> (!fd_valid_o && addr_o == $past(addr_o)));

endmodule

// File: rtl/p4_regfile.sv
module p4_regfile
  import pipe4_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TAG_W-1:0]  rtag_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] regs_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] q;
    assign hit = we_i && (wtag_i == TAG_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wdata_i;
    end
    assign regs_q[g] = q;
  end

  // same-cycle pass-through of the value being stored
  assign rdata_o = (we_i && (wtag_i == rtag_i)) ? wdata_i : regs_q[rtag_i];

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wtag_i)] == $past(wdata_i));

endmodule

// File: rtl/p4_decode.sv
module p4_decode
  import pipe4_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fd_valid_i,
  input  instr_t            fd_instr_i,
  input  logic              busy_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              hazard_o,
  output logic              de_valid_o,
  output op_e               de_op_o,
  output logic [LAT_W-1:0]  de_xlat_o,
  output logic [TAG_W-1:0]  de_dst_o,
  output logic [DATA_W-1:0] de_opnd_o,
  output logic [IMM_W-1:0]  de_imm_o
);

  logic              v_q, v_d;
  logic              data_en;
  op_e               op_q;
  logic [LAT_W-1:0]  xlat_q;
  logic [TAG_W-1:0]  dst_q;
  logic [DATA_W-1:0] opnd_q;
  logic [IMM_W-1:0]  imm_q;

  assign rd_tag_o = fd_instr_i.src;

  // read-after-write check against the token now in execute
  assign hazard_o = fd_valid_i && reads_src(fd_instr_i.op) &&
                    v_q && (dst_q == fd_instr_i.src);

  always_comb begin
    v_d     = v_q;
    data_en = 1'b0;
    if (!busy_i) begin
      v_d     = fd_valid_i && !hazard_o;
      data_en = v_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= 1'b0;
    else         v_q <= v_d;
  end

  always_ff @(posedge clk_i) begin
    if (data_en) begin
      op_q   <= fd_instr_i.op;
      xlat_q <= fd_instr_i.xlat;
      dst_q  <= fd_instr_i.dst;
      opnd_q <= rd_data_i;
      imm_q  <= fd_instr_i.imm;
    end
  end

  assign de_valid_o = v_q;
  assign de_op_o    = op_q;
  assign de_xlat_o  = xlat_q;
  assign de_dst_o   = dst_q;
  assign de_opnd_o  = opnd_q;
  assign de_imm_o   = imm_q;

  assert_raw_inserts_bubble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hazard_o && !busy_i) |=> !de_valid_o);

  assert_busy_keeps_exec_input_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> de_valid_o && $stable(de_dst_o) && $stable(de_opnd_o) && $stable(de_xlat_o));

endmodule

// File: rtl/p4_execute.sv
module p4_execute
  import pipe4_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_valid_i,
  input  op_e               de_op_i,
  input  logic [LAT_W-1:0]  de_xlat_i,
  input  logic [TAG_W-1:0]  de_dst_i,
  input  logic [DATA_W-1:0] de_opnd_i,
  input  logic [IMM_W-1:0]  de_imm_i,
  output logic              busy_o,
  output logic              es_valid_o,
  output logic [TAG_W-1:0]  es_dst_o,
  output logic [DATA_W-1:0] es_value_o
);

  logic [LAT_W-1:0]  cnt_q, cnt_d;
  logic              done;
  logic [DATA_W-1:0] result;
  logic              v_q;
  logic [TAG_W-1:0]  dst_q;
  logic [DATA_W-1:0] val_q;

  assign done   = de_valid_i && (cnt_q == de_xlat_i);
  assign busy_o = de_valid_i && !done;

  always_comb begin
    cnt_d = '0;
    if (busy_o) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    case (de_op_i)
      OP_ADDI: result = de_opnd_i + DATA_W'(de_imm_i);
      OP_MULI: result = de_opnd_i * DATA_W'(de_imm_i);
      default: result = DATA_W'(de_imm_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      v_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      v_q   <= done;
    end
  end

  always_ff @(posedge clk_i) begin
    if (done) begin
      dst_q <= de_dst_i;
      val_q <= result;
    end
  end

  assign es_valid_o = v_q;
  assign es_dst_o   = dst_q;
  assign es_value_o = val_q;

  assert_count_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_valid_i |-> cnt_q <= de_xlat_i);

  assert_stall_feeds_bubble_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !es_valid_o);

  assert_idle_count_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_valid_i |=> cnt_q == '0);

endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [PC_W-1:0]    fetch_addr_o,
  input  logic [INSTR_W-1:0] fetch_word_i,
  output logic               stall_o,
  output logic               retire_valid_o,
  output logic [TAG_W-1:0]   retire_tag_o,
  output logic [DATA_W-1:0]  retire_value_o
);

  logic              fd_valid;
  instr_t            fd_instr;
  logic              hazard;
  logic              busy;
  logic              hold_front;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              de_valid;
  op_e               de_op;
  logic [LAT_W-1:0]  de_xlat;
  logic [TAG_W-1:0]  de_dst;
  logic [DATA_W-1:0] de_opnd;
  logic [IMM_W-1:0]  de_imm;
  logic              es_valid;
  logic [TAG_W-1:0]  es_dst;
  logic [DATA_W-1:0] es_value;

  assign hold_front = busy || hazard;

  p4_fetch #(.PC_W(PC_W)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold_front),
    .word_i     (fetch_word_i),
    .addr_o     (fetch_addr_o),
    .fd_valid_o (fd_valid),
    .fd_instr_o (fd_instr)
  );

  p4_decode #(.DATA_W(DATA_W)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fd_valid_i (fd_valid),
    .fd_instr_i (fd_instr),
    .busy_i     (busy),
    .rd_tag_o   (rd_tag),
    .rd_data_i  (rd_data),
    .hazard_o   (hazard),
    .de_valid_o (de_valid),
    .de_op_o    (de_op),
    .de_xlat_o  (de_xlat),
    .de_dst_o   (de_dst),
    .de_opnd_o  (de_opnd),
    .de_imm_o   (de_imm)
  );

  p4_execute #(.DATA_W(DATA_W)) u_execute (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .de_valid_i (de_valid),
    .de_op_i    (de_op),
    .de_xlat_i  (de_xlat),
    .de_dst_i   (de_dst),
    .de_opnd_i  (de_opnd),
    .de_imm_i   (de_imm),
    .busy_o     (busy),
    .es_valid_o (es_valid),
    .es_dst_o   (es_dst),
    .es_value_o (es_value)
  );

  // store stage: the exec/store holding register writes the register file
  p4_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (es_valid),
    .wtag_i  (es_dst),
    .wdata_i (es_value),
    .rtag_i  (rd_tag),
    .rdata_o (rd_data)
  );

  assign stall_o        = busy;
  assign retire_valid_o = es_valid;
  assign retire_tag_o   = es_dst;
  assign retire_value_o = es_value;

  assert_stall_freezes_pointer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> fetch_addr_o == $past(fetch_addr_o));

endmodule

// File: tb/test_pipe4_core.sv
`timescale 1ns/1ps
module test_pipe4_core;

  localparam int DW = 16;
  localparam int PW = 4;
  localparam int IW = 18;
  localparam int NSLOT = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [IW-1:0] rom [NSLOT];
  logic [PW-1:0] fetch_addr;
  logic [IW-1:0] fetch_word;
  logic          stall;
  logic          rv;
  logic [2:0]    rtag;
  logic [DW-1:0] rval;

  assign fetch_word = rom[fetch_addr];

  pipe4_core i_pipe4_core (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .fetch_addr_o   (fetch_addr),
    .fetch_word_i   (fetch_word),
    .stall_o        (stall),
    .retire_valid_o (rv),
    .retire_tag_o   (rtag),
    .retire_value_o (rval)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected schedule per token
  int n_tok;
  int t_ret[NSLOT];
  int t_dec[NSLOT];
  int t_lat[NSLOT];
  int t_dst[NSLOT];
  int t_val[NSLOT];

  function automatic logic [IW-1:0] enc(int op, int lat, int dst, int src, int imm);
    int w;
    w = (op << 16) | (lat << 14) | (dst << 11) | (src << 8) | (imm & 255);
    return w[IW-1:0];
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < NSLOT; i++) rom[i] = '0;
  endtask

  // sequential reference plus timing equations for the schedule
  task automatic build_model();
    int regs[8];
    int f, xprev, prevdst, d, op, lat, dst, src, imm, v, dep;
    for (int r = 0; r < 8; r++) regs[r] = 0;
    f = 1; xprev = 0; prevdst = -1; n_tok = 0;
    for (int i = 0; i < NSLOT; i++) begin
      op  = int'(rom[i][17:16]);
      if (op == 0) break;
      lat = int'(rom[i][15:14]);
      dst = int'(rom[i][13:11]);
      src = int'(rom[i][10:8]);
      imm = int'(rom[i][7:0]);
      dep = ((op == 1 || op == 2) && src == prevdst) ? 1 : 0;
      d = (f + 1 > xprev + dep) ? f + 1 : xprev + dep;
      case (op)
        1:       v = (regs[src] + imm) & 32'hFFFF;
        2:       v = (regs[src] * imm) & 32'hFFFF;
        default: v = imm;
      endcase
      regs[dst] = v;
      t_dec[i] = d;
      t_lat[i] = lat;
      t_ret[i] = d + lat + 1;
      t_dst[i] = dst;
      t_val[i] = v;
      f = d;
      xprev = t_ret[i];
      prevdst = dst;
      n_tok++;
    end
  endtask

  task automatic run_prog(string tag);
    int last, hit, st;
    build_model();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", "fetch_addr in reset", int'(fetch_addr), 0);
    check("R1", "stall in reset", int'(stall), 0);
    check("R1", "retire_valid in reset", int'(rv), 0);
    rst_n = 1'b1;
    last = (n_tok > 0) ? t_ret[n_tok-1] : 1;
    for (int k = 1; k <= last + 3; k++) begin
      @(negedge clk);
      hit = -1;
      st  = 0;
      for (int i = 0; i < n_tok; i++) begin
        if (t_ret[i] == k) hit = i;
        if (k >= t_dec[i] && k <= t_dec[i] + t_lat[i] - 1) st = 1;
      end
      check("R4", $sformatf("%s stall after edge %0d", tag, k), int'(stall), st);
      check(tag, $sformatf("R5 retire_valid after edge %0d", k), int'(rv), (hit >= 0) ? 1 : 0);
      if (hit >= 0 && rv) begin
        check("R9", $sformatf("%s retire tag token %0d", tag, hit), int'(rtag), t_dst[hit]);
        check("R2", $sformatf("%s retire value token %0d", tag, hit), int'(rval), t_val[hit]);
      end
    end
    check("R8", $sformatf("%s fetch_addr parked on end marker", tag), int'(fetch_addr), n_tok);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_rom();

    // R3: four independent single-cycle loads
    rom[0] = enc(3, 0, 1, 0, 3);
    rom[1] = enc(3, 0, 2, 0, 5);
    rom[2] = enc(3, 0, 3, 0, 7);
    rom[3] = enc(3, 0, 4, 0, 9);
    run_prog("R3");

    // R4/R5 and R1: multi-cycle execute; r3 read after reset must be zero
    clear_rom();
    rom[0] = enc(3, 0, 1, 0, 1);
    rom[1] = enc(1, 2, 2, 3, 4);
    rom[2] = enc(3, 0, 4, 0, 6);
    rom[3] = enc(3, 3, 5, 0, 11);
    rom[4] = enc(1, 0, 6, 1, 1);
    run_prog("R5");

    // R6: 10, +5 (two cycles), x2 -> 30, with back-to-back dependences
    clear_rom();
    rom[0] = enc(3, 0, 1, 0, 10);
    rom[1] = enc(1, 1, 1, 1, 5);
    rom[2] = enc(2, 0, 2, 1, 2);
    rom[3] = enc(1, 0, 3, 2, 0);
    run_prog("R6");

    // R7: source written two tokens ahead, seen through the store bypass
    clear_rom();
    rom[0] = enc(3, 0, 1, 0, 6);
    rom[1] = enc(3, 0, 2, 0, 1);
    rom[2] = enc(1, 0, 3, 1, 1);
    rom[3] = enc(3, 2, 5, 0, 2);
    rom[4] = enc(2, 0, 4, 3, 3);
    run_prog("R7");

    // R10: load whose src matches the destination ahead causes no delay
    clear_rom();
    rom[0] = enc(3, 0, 3, 0, 8);
    rom[1] = enc(3, 0, 5, 3, 2);
    rom[2] = enc(3, 0, 6, 5, 200);
    rom[3] = enc(2, 0, 7, 6, 255);
    run_prog("R10");

    // R8: end marker in the first slot
    clear_rom();
    run_prog("R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule